// File: doc/BRIEF.md
# Dual-Period Token Bucket Rate Limiter

This block meters a single transmit stream. It holds a signed token counter that is refilled on two nested periods. A short cycle lasts a set number of clocks, and each one adds a short increment to the counter. Once a set number of short cycles have passed, a long cycle ends and adds a second increment on the same edge. The counter never rises above a maximum burst size. Charges may push it below zero, down to the most negative value that its width can hold.

An upstream requester presents a request with a byte length and a type. The grant is combinational and appears in the same cycle as the request. A request that the limiter meters is granted only while the counter is positive. The charge is then taken on the next clock edge. In byte mode the charge is eight token units per byte. In packet mode the charge is one token unit per packet. A mask chooses which request types are metered. A two-bit command input enables, pauses or resets the limiter. All other configuration comes from static inputs that change only while the block is held in reset.

Top module: `token_rate_limiter`

## Requirements
- R1: After rst_n is released, tokenLevel equals the smaller of cfgInitTokens and cfgMaxBurst. The limiter is disabled and not paused, and both cycle counters are zero.
- R2: While the limiter is enabled and not paused, every cfgShortLen clocks adds cfgShortInc to the counter. A cfgShortLen of 0 behaves as 1. The addition appears in tokenLevel after the edge that ends the short cycle.
- R3: On every cfgLongCount-th short-cycle end, cfgLongInc is also added on the same edge. A cfgLongCount of 0 behaves as 1.
- R4: tokenLevel never exceeds cfgMaxBurst. A refill that would go past it leaves the counter at cfgMaxBurst.
- R5: Take a metered request, meaning the limiter is enabled and cfgMask[reqType] is 1. While not paused, it is granted in the same cycle if and only if tokenLevel is greater than 0. Each grant subtracts reqLen*8 at the next edge, and refill and charge combine on that same edge.
- R6: When cfgPktMode is 1, each granted metered request subtracts exactly 1, whatever its reqLen.
- R7: A charge that would take the counter below -2^(TOKEN_W-1) leaves it at -2^(TOKEN_W-1).
- R8: A request whose type has its cfgMask bit at 0 is always granted and does not change tokenLevel.
- R9: While the limiter is disabled, every valid request is granted, and neither tokenLevel nor the cycle counters change.
- R10: cmdOp=2 (pause) takes effect from the next cycle. From then on, metered requests are refused, refill stops and the cycle counters hold. cmdOp=1 (enable) clears the pause and enables the limiter from the next cycle. cmdOp=0 does nothing.
- R11: cmdOp=3 (reset) causes the following at the next edge. tokenLevel reloads to the smaller of cfgInitTokens and cfgMaxBurst, both cycle counters clear, and the limiter becomes disabled and unpaused. This overrides any refill or charge in that cycle, although the request in that cycle is still granted according to the state at the time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgPktMode | input | 1 | 1: charge one per packet; 0: charge eight per byte |
| cfgMask | input | TYPES | Per request type, 1 = metered |
| cfgShortLen | input | CYC_W | Clocks per short cycle (0 acts as 1) |
| cfgLongCount | input | LONG_W | Short cycles per long cycle (0 acts as 1) |
| cfgShortInc | input | INC_W | Tokens added per short cycle |
| cfgLongInc | input | INC_W | Tokens added per long cycle |
| cfgMaxBurst | input | TOKEN_W-1 | Counter ceiling |
| cfgInitTokens | input | TOKEN_W-1 | Value loaded on reset |
| cmdOp | input | 2 | 0 none, 1 enable, 2 pause, 3 reset |
| reqValid | input | 1 | Request present |
| reqLen | input | LEN_W | Request length in bytes |
| reqType | input | TYPE_W | Request type, indexes cfgMask |
| reqGrant | output | 1 | Request allowed this cycle |
| tokenLevel | output | TOKEN_W | Signed token counter |

## Verification
The bench targets four boundaries:
- The edge where a short cycle and a long cycle end together. A design that staggered the two additions would show an off-by-one level on that edge.
- The clamp at the burst ceiling. A design missing it would let tokenLevel exceed cfgMaxBurst.
- The negative floor, reached with one oversized charge. A design without saturation would wrap to a large positive level and grant wrongly.
- The grant at exactly zero tokens. A design testing for non-negative instead of positive would let one extra request through.

The bench also places a reset command in the same cycle as a granted charge, and sends bypassed types while paused. Zero-valued period settings are covered as well, since a design that decremented them without a guard would stall the refill.

// File: rtl/trl_pkg.sv
package trl_pkg;
  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_ENABLE = 2'd1,
    CMD_PAUSE  = 2'd2,
    CMD_RESET  = 2'd3
  } cmd_e;

  // Strobes from the control to the token datapath, valid for one edge.
  typedef struct packed {
    logic load;      // reload the initial value
    logic addShort;  // short-cycle refill
    logic addLong;   // long-cycle refill
    logic charge;    // subtract the cost of the current request
  } tokStrobe_t;
endpackage

// File: rtl/trl_ctrl.sv
module trl_ctrl
  import trl_pkg::*;
#(
  parameter int TYPES  = 2,
  parameter int TYPE_W = 1,
  parameter int CYC_W  = 8,
  parameter int LONG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmdOp,
  input  logic [TYPES-1:0]  cfgMask,
  input  logic [CYC_W-1:0]  cfgShortLen,
  input  logic [LONG_W-1:0] cfgLongCount,
  input  logic              reqValid,
  input  logic [TYPE_W-1:0] reqType,
  input  logic              tokPositive,
  output logic              reqGrant,
  output tokStrobe_t        strobe,
  output logic              limEnabled,
  output logic              limPaused
);
  cmd_e              cmd;
  logic [CYC_W-1:0]  shortCnt;
  logic [LONG_W-1:0] longCnt;
  logic [CYC_W-1:0]  shortLastIdx;
  logic [LONG_W-1:0] longLastIdx;
  logic              shortLast, longLast, running, metered;

  assign cmd          = cmd_e'(cmdOp);
  assign shortLastIdx = (cfgShortLen == '0) ? '0 : cfgShortLen - CYC_W'(1);
  assign longLastIdx  = (cfgLongCount == '0) ? '0 : cfgLongCount - LONG_W'(1);
  assign shortLast    = shortCnt >= shortLastIdx;
  assign longLast     = longCnt >= longLastIdx;
  assign running      = limEnabled && !limPaused;
  assign metered      = limEnabled && cfgMask[reqType];

  assign reqGrant = reqValid && (!metered || (!limPaused && tokPositive));

  always_comb begin
    strobe.load     = (cmd == CMD_RESET);
    strobe.addShort = running && shortLast && !strobe.load;
    strobe.addLong  = strobe.addShort && longLast;
    strobe.charge   = reqGrant && metered && !strobe.load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limEnabled <= 1'b0;
      limPaused  <= 1'b0;
      shortCnt   <= '0;
      longCnt    <= '0;
    end else begin
      unique case (cmd)
        CMD_ENABLE: begin limEnabled <= 1'b1; limPaused <= 1'b0; end
        CMD_PAUSE:  limPaused <= 1'b1;
        CMD_RESET:  begin limEnabled <= 1'b0; limPaused <= 1'b0; end
        default: ;
      endcase
      if (cmd == CMD_RESET) begin
        shortCnt <= '0;
        longCnt  <= '0;
      end else if (running) begin
        if (shortLast) begin
          shortCnt <= '0;
          longCnt  <= longLast ? '0 : longCnt + LONG_W'(1);
        end else begin
          shortCnt <= shortCnt + CYC_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/trl_datapath.sv
module trl_datapath
  import trl_pkg::*;
#(
  parameter int TOKEN_W = 16,
  parameter int INC_W   = 12,
  parameter int LEN_W   = 13
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  tokStrobe_t                strobe,
  input  logic                      cfgPktMode,
  input  logic [LEN_W-1:0]          reqLen,
  input  logic [INC_W-1:0]          cfgShortInc,
  input  logic [INC_W-1:0]          cfgLongInc,
  input  logic [TOKEN_W-2:0]        cfgMaxBurst,
  input  logic [TOKEN_W-2:0]        cfgInitTokens,
  output logic signed [TOKEN_W-1:0] tokenLevel,
  output logic                      tokPositive
);
  localparam int WIDEST = (TOKEN_W > INC_W + 1) ?
                          ((TOKEN_W > LEN_W + 4) ? TOKEN_W : LEN_W + 4) :
                          ((INC_W + 1 > LEN_W + 4) ? INC_W + 1 : LEN_W + 4);
  localparam int EXT_W = WIDEST + 2;
  localparam logic signed [EXT_W-1:0] TOK_MIN_EXT =
    {{(EXT_W-TOKEN_W+1){1'b1}}, {(TOKEN_W-1){1'b0}}};

  logic signed [EXT_W-1:0] maxExt, initExt, tokExt, incS, incL, cost, sum;
  logic signed [TOKEN_W-1:0] loadVal, nextVal;

  function automatic logic signed [TOKEN_W-1:0] clampTok(
      input logic signed [EXT_W-1:0] v, input logic signed [EXT_W-1:0] hi);
    logic signed [EXT_W-1:0] r;
    if (v > hi)               r = hi;
    else if (v < TOK_MIN_EXT) r = TOK_MIN_EXT;
    else                      r = v;
    return r[TOKEN_W-1:0];
  endfunction

  always_comb begin
    maxExt  = {{(EXT_W-TOKEN_W+1){1'b0}}, cfgMaxBurst};
    initExt = {{(EXT_W-TOKEN_W+1){1'b0}}, cfgInitTokens};
    tokExt  = {{(EXT_W-TOKEN_W){tokenLevel[TOKEN_W-1]}}, tokenLevel};
    incS    = strobe.addShort ? {{(EXT_W-INC_W){1'b0}}, cfgShortInc} : '0;
    incL    = strobe.addLong  ? {{(EXT_W-INC_W){1'b0}}, cfgLongInc}  : '0;
    if (!strobe.charge)  cost = '0;
    else if (cfgPktMode) cost = EXT_W'(1);
    else                 cost = {{(EXT_W-LEN_W-3){1'b0}}, reqLen, 3'b000};
    sum     = tokExt + incS + incL - cost;
    loadVal = clampTok(initExt, maxExt);
    nextVal = clampTok(sum, maxExt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       tokenLevel <= loadVal;
    else if (strobe.load)                             tokenLevel <= loadVal;
    else if (strobe.addShort || strobe.charge)        tokenLevel <= nextVal;
  end

  assign tokPositive = !tokenLevel[TOKEN_W-1] && (tokenLevel != '0);
endmodule

// File: rtl/token_rate_limiter.sv
module token_rate_limiter
  import trl_pkg::*;
#(
  parameter int TOKEN_W = 16,
  parameter int INC_W   = 12,
  parameter int LEN_W   = 13,
  parameter int CYC_W   = 8,
  parameter int LONG_W  = 8,
  parameter int TYPES   = 2,
  localparam int TYPE_W = (TYPES > 1) ? $clog2(TYPES) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfgPktMode,
  input  logic [TYPES-1:0]          cfgMask,
  input  logic [CYC_W-1:0]          cfgShortLen,
  input  logic [LONG_W-1:0]         cfgLongCount,
  input  logic [INC_W-1:0]          cfgShortInc,
  input  logic [INC_W-1:0]          cfgLongInc,
  input  logic [TOKEN_W-2:0]        cfgMaxBurst,
  input  logic [TOKEN_W-2:0]        cfgInitTokens,
  input  logic [1:0]                cmdOp,
  input  logic                      reqValid,
  input  logic [LEN_W-1:0]          reqLen,
  input  logic [TYPE_W-1:0]         reqType,
  output logic                      reqGrant,
  output logic signed [TOKEN_W-1:0] tokenLevel
);
  tokStrobe_t strobe;
  logic       tokPositive;
  logic       limEnabled, limPaused;

  trl_ctrl #(.TYPES(TYPES), .TYPE_W(TYPE_W), .CYC_W(CYC_W), .LONG_W(LONG_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdOp(cmdOp), .cfgMask(cfgMask),
    .cfgShortLen(cfgShortLen), .cfgLongCount(cfgLongCount),
    .reqValid(reqValid), .reqType(reqType), .tokPositive(tokPositive),
    .reqGrant(reqGrant), .strobe(strobe),
    .limEnabled(limEnabled), .limPaused(limPaused)
  );

  trl_datapath #(.TOKEN_W(TOKEN_W), .INC_W(INC_W), .LEN_W(LEN_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cfgPktMode(cfgPktMode),
    .reqLen(reqLen), .cfgShortInc(cfgShortInc), .cfgLongInc(cfgLongInc),
    .cfgMaxBurst(cfgMaxBurst), .cfgInitTokens(cfgInitTokens),
    .tokenLevel(tokenLevel), .tokPositive(tokPositive)
  );
endmodule

// File: rtl/trl_checker.sv
module trl_checker #(
  parameter int TOKEN_W = 16,
  parameter int TYPES   = 2,
  parameter int TYPE_W  = 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [TYPES-1:0]          cfgMask,
  input logic [TOKEN_W-2:0]        cfgMaxBurst,
  input logic [TOKEN_W-2:0]        cfgInitTokens,
  input logic [1:0]                cmdOp,
  input logic                      reqValid,
  input logic [TYPE_W-1:0]         reqType,
  input logic                      reqGrant,
  input logic signed [TOKEN_W-1:0] tokenLevel,
  input logic                      limEnabled,
  input logic                      limPaused
);
  logic signed [TOKEN_W-1:0] capS, reloadS;
  assign capS    = $signed({1'b0, cfgMaxBurst});
  assign reloadS = (cfgInitTokens > cfgMaxBurst) ? capS : $signed({1'b0, cfgInitTokens});

  AST_TOKEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    tokenLevel <= capS); // R4

  AST_DRY_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (limEnabled && cfgMask[reqType] && reqGrant) |-> (tokenLevel > 0)); // R5

  AST_BYPASS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !cfgMask[reqType]) |-> reqGrant); // R8

  AST_DISABLED_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !limEnabled) |-> reqGrant); // R9

  AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!limEnabled && cmdOp != 2'd3) |=> $stable(tokenLevel)); // R9

  AST_PAUSE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (limEnabled && limPaused && cmdOp != 2'd3) |=> $stable(tokenLevel)); // R10

  AST_PAUSE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (limEnabled && limPaused && cfgMask[reqType]) |-> !reqGrant); // R10

  AST_RESET_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdOp == 2'd3) |=> (tokenLevel == reloadS && !limEnabled)); // R11
endmodule

bind token_rate_limiter trl_checker #(.TOKEN_W(TOKEN_W), .TYPES(TYPES), .TYPE_W(TYPE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cfgMask(cfgMask), .cfgMaxBurst(cfgMaxBurst),
  .cfgInitTokens(cfgInitTokens), .cmdOp(cmdOp), .reqValid(reqValid),
  .reqType(reqType), .reqGrant(reqGrant), .tokenLevel(tokenLevel),
  .limEnabled(limEnabled), .limPaused(limPaused)
);

// File: tb/test_token_rate_limiter.sv
`timescale 1ns/1ps
module test_token_rate_limiter;
  localparam int TOKEN_W = 16, INC_W = 12, LEN_W = 13, CYC_W = 8, LONG_W = 8, TYPES = 2;
  localparam int TOK_MIN = -(1 << (TOKEN_W-1));

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfgPktMode;
  logic [TYPES-1:0] cfgMask;
  logic [CYC_W-1:0] cfgShortLen;
  logic [LONG_W-1:0] cfgLongCount;
  logic [INC_W-1:0] cfgShortInc, cfgLongInc;
  logic [TOKEN_W-2:0] cfgMaxBurst, cfgInitTokens;
  logic [1:0] cmdOp = 2'd0;
  logic reqValid = 1'b0;
  logic [LEN_W-1:0] reqLen = '0;
  logic [0:0] reqType = '0;
  logic reqGrant;
  logic signed [TOKEN_W-1:0] tokenLevel;

  token_rate_limiter #(.TOKEN_W(TOKEN_W), .INC_W(INC_W), .LEN_W(LEN_W),
    .CYC_W(CYC_W), .LONG_W(LONG_W), .TYPES(TYPES)) i_token_rate_limiter (
    .clk(clk), .rst_n(rst_n), .cfgPktMode(cfgPktMode), .cfgMask(cfgMask),
    .cfgShortLen(cfgShortLen), .cfgLongCount(cfgLongCount),
    .cfgShortInc(cfgShortInc), .cfgLongInc(cfgLongInc),
    .cfgMaxBurst(cfgMaxBurst), .cfgInitTokens(cfgInitTokens),
    .cmdOp(cmdOp), .reqValid(reqValid), .reqLen(reqLen), .reqType(reqType),
    .reqGrant(reqGrant), .tokenLevel(tokenLevel));

  always #2.5 clk = ~clk;

  int nCmp = 0, nBad = 0;
  bit finished = 0;
  string curReq = "R1";
  int mTok, mShort, mLong;
  bit mEn, mPause;

  function automatic int reloadVal();
    return (int'(cfgInitTokens) > int'(cfgMaxBurst)) ? int'(cfgMaxBurst) : int'(cfgInitTokens);
  endfunction

  task automatic check(string what, int got, int exp);
    nCmp++;
    if (got != exp) begin
      nBad++;
      $display("FAIL %s %s: got %0d expected %0d", curReq, what, got, exp);
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0; cmdOp = 2'd0; reqValid = 1'b0;
    repeat (2) @(negedge clk);
    mTok = reloadVal(); mShort = 0; mLong = 0; mEn = 0; mPause = 0;
    rst_n = 1'b1;
  endtask

  // Called at a falling edge; ends at the next falling edge.
  task automatic step(int op, bit v, int len, int typ);
    bit lim, eg, sl, ll;
    int add, chg, t, lastS, lastL;
    cmdOp = op[1:0]; reqValid = v; reqLen = len[LEN_W-1:0]; reqType = typ[0:0];
    #1;
    lim = mEn && cfgMask[typ];
    eg  = v && (!lim || (!mPause && mTok > 0));
    check("reqGrant", int'(reqGrant), int'(eg));
    check("tokenLevel", int'(tokenLevel), mTok);
    if (op == 3) begin
      mTok = reloadVal(); mShort = 0; mLong = 0; mEn = 0; mPause = 0;
    end else begin
      add = 0;
      if (mEn && !mPause) begin
        lastS = (cfgShortLen == 0) ? 0 : int'(cfgShortLen) - 1;
        lastL = (cfgLongCount == 0) ? 0 : int'(cfgLongCount) - 1;
        sl = mShort >= lastS;
        if (sl) begin
          add += int'(cfgShortInc);
          ll = mLong >= lastL;
          if (ll) add += int'(cfgLongInc);
          mLong = ll ? 0 : mLong + 1;
          mShort = 0;
        end else mShort++;
      end
      chg = (eg && lim) ? (cfgPktMode ? 1 : len * 8) : 0;
      t = mTok + add - chg;
      if (t > int'(cfgMaxBurst)) t = int'(cfgMaxBurst);
      if (t < TOK_MIN) t = TOK_MIN;
      mTok = t;
      if (op == 1) begin mEn = 1; mPause = 0; end
      else if (op == 2) mPause = 1;
    end
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    cfgPktMode = 0; cfgMask = 2'b01; cfgShortLen = 3; cfgLongCount = 4;
    cfgShortInc = 10; cfgLongInc = 100; cfgMaxBurst = 500; cfgInitTokens = 600;
    doReset();
    curReq = "R1"; // reload clamped to 500, disabled
    repeat (3) step(0, 0, 0, 0);
    curReq = "R9";
    repeat (5) step(0, 1, 20, 0);
    curReq = "R5"; // enable then drain with 160-token requests
    step(1, 0, 0, 0);
    repeat (12) step(0, 1, 20, 0);
    curReq = "R2"; // refill from the deficit, including joint short+long edges (R3)
    repeat (30) step(0, 0, 0, 0);
    curReq = "R3";
    repeat (30) step(0, 0, 0, 0);
    curReq = "R4";
    repeat (40) step(0, 0, 0, 0);
    curReq = "R8";
    repeat (6) step(0, 1, 100, 1);
    curReq = "R10";
    step(2, 1, 10, 0);
    repeat (8) step(0, 1, 10, 0);
    repeat (3) step(0, 1, 10, 1);
    step(1, 0, 0, 0);
    repeat (10) step(0, 1, 5, 0);
    curReq = "R11";
    step(3, 1, 30, 0);
    repeat (4) step(0, 1, 30, 0);
    step(1, 0, 0, 0);
    repeat (5) step(0, 0, 0, 0);

    cfgMaxBurst = 20; cfgInitTokens = 5; cfgShortLen = 0; cfgLongCount = 0;
    cfgShortInc = 1; cfgLongInc = 2;
    doReset();
    curReq = "R7";
    step(1, 0, 0, 0);
    step(0, 1, 8191, 0);
    repeat (6) step(0, 1, 4, 0);
    curReq = "R2";
    repeat (20) step(0, 0, 0, 0);

    cfgPktMode = 1; cfgMaxBurst = 4; cfgInitTokens = 3; cfgShortLen = 5;
    cfgLongCount = 2; cfgShortInc = 1; cfgLongInc = 0;
    doReset();
    curReq = "R6";
    step(1, 0, 0, 0);
    repeat (40) step(0, 1, 1000, 0);

    cfgPktMode = 0; cfgMask = 2'b11; cfgMaxBurst = 3000; cfgInitTokens = 800;
    cfgShortLen = 2; cfgLongCount = 3; cfgShortInc = 25; cfgLongInc = 60;
    doReset();
    curReq = "R5";
    step(1, 0, 0, 0);
    for (int i = 0; i < 600; i++) begin
      int r, op;
      r = int'($urandom_range(0, 255));
      op = (r < 2) ? 3 : (r < 8) ? 2 : (r < 24) ? 1 : 0;
      step(op, $urandom_range(0, 1) == 1, int'($urandom_range(0, 40)), int'($urandom_range(0, 1)));
    end
    summary();
  end
endmodule